// File: doc/BRIEF.md
# Pseudo-SRAM Power and Mode Sequencer

This block owns the control pins of a pseudo-static RAM while the memory is powering up, while its mode register is being loaded and while it is in a low-power state. It does not carry data. When none of these sequences is running, it raises `grant` so that a separate access controller can take over the bus. All timing is counted in clock cycles. Each nanosecond limit is turned into a cycle count using the clock-period parameter, and the count is rounded up.

Once `supply_ok` is high, the block holds chip-select and the sleep pin high for the power-up interval, then reports that it is initialised. It accepts three one-cycle commands:

- **Program:** loads a 5-bit value into the mode register through a special bus cycle. The sleep pin is low, chip-select and both byte enables are high, and the value is on the low address bits.
- **Sleep:** drives the sleep pin low and holds it low for at least the minimum sleep time.
- **Wake:** releases the sleep pin. If the programmed mode destroys data in sleep, the block also enforces a long recovery wait before the next access.

A command that cannot be accepted in the current state is dropped and flagged with a one-cycle error pulse.

Top module: `psram_pwr_seq`

## Requirements
- R1: While `supply_ok` is low, the outputs are `zz_n`, `ce_n`, `we_n`, `oe_n`, `bhe_n`, `ble_n` all 1, `grant`=0, `init_done`=0, `busy`=1 and `asleep`=0.
- R2: `grant` and `init_done` rise together. This happens PWRUP_CYC cycles after the edge that first samples `supply_ok` high. During that interval `zz_n` and `ce_n` stay at 1. `grant` is never 1 while `init_done` is 0.
- R3: A program cycle drives `zz_n`=0 in the cycle after the command is accepted. `ce_n`, `bhe_n`, `ble_n` and `oe_n` are 1 whenever `zz_n` is 0. `we_n` falls only after `zz_n` has been low for at least SETUP_CYC cycles.
- R4: In a program cycle, `we_n` is low for exactly WE_CYC cycles. While `we_n` is low, `addr_o[4:0]` carries the command value and the upper address bits are 0. `grant` returns SETUP_CYC+WE_CYC+1 cycles after it drops.
- R5: The stored mode is classified from value bit 4. Bit 4 = 0 is the data-losing deep mode. Bit 4 = 1 is a retaining mode: bit 3 = 0 selects partial refresh and bit 3 = 1 selects reduced size. After power-up, the mode is a retaining one.
- R6: A sleep command drives `zz_n`=0 with `ce_n`=1 and `asleep`=1. `busy` stays 1 for the first SLEEP_CYC cycles. After that, `busy` falls and only then is wake accepted.
- R7: When the mode is retaining, an accepted wake raises `zz_n` and `grant` and clears `asleep` on the next edge.
- R8: When the mode is deep, an accepted wake raises `zz_n` at once. `grant` is held off for REC_CYC cycles, with `busy`=1 during that time.
- R9: `grant` is 1 only when nothing is in progress. `grant` and `busy` are never 1 together.
- R10: Several things cause a command to be ignored with `cmd_err` pulsed for one cycle after it is sampled:
  - more than one command asserted at once;
  - program or sleep arriving while not idle;
  - wake arriving outside settled sleep.
- R11: A fall of `supply_ok` returns the block to the R1 state on the next edge and resets the mode to a retaining one. The full power-up wait is then repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply stable indication |
| cmd_prog | input | 1 | Program mode-register command |
| cmd_sleep | input | 1 | Enter sleep command |
| cmd_wake | input | 1 | Leave sleep command |
| prog_val | input | 5 | Mode-register value for a program command |
| zz_n | output | 1 | Sleep/mode pin, active low |
| ce_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| bhe_n | output | 1 | Upper byte enable, active low |
| ble_n | output | 1 | Lower byte enable, active low |
| addr_o | output | ADDR_W | Address pins |
| grant | output | 1 | Bus handed to the access controller |
| busy | output | 1 | A sequence is running |
| init_done | output | 1 | Power-up wait completed |
| asleep | output | 1 | Memory is in sleep |
| cmd_err | output | 1 | One-cycle pulse: command dropped |

## Verification
A wrong sequencer state shows up at the pins within one cycle, because each pin is a registered decode of the next state. Two examples: a grant asserted during a sequence, or a write strobe while the sleep pin is high. A wrong counter load does not show as a pin level. It shows as a wrong interval length, visible only once the interval ends, which can be hundreds of cycles later. A wrongly recorded mode stays hidden until the next wake, when the grant either arrives at once or only after the recovery wait.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

    typedef enum logic [3:0] {
        ST_NOSUPPLY,
        ST_PWRUP,
        ST_IDLE,
        ST_PRG_SETUP,
        ST_PRG_STROBE,
        ST_PRG_HOLD,
        ST_SLP_MIN,
        ST_SLP,
        ST_RECOVER
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SLEEP,
        OP_WAKE
    } seq_op_e;

    typedef enum logic [1:0] {
        RM_FULL,
        RM_PARTIAL,
        RM_REDUCED,
        RM_DEEP
    } ret_mode_e;

    typedef struct packed {
        logic zz_n;
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic bhe_n;
        logic ble_n;
        logic grant;
        logic busy;
        logic asleep;
    } pin_set_t;

    // Rounded-up conversion of a time limit into whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic ret_mode_e classify(input logic [4:0] v);
        if (!v[4])     return RM_DEEP;
        else if (v[3]) return RM_REDUCED;
        else           return RM_PARTIAL;
    endfunction

    // Pin and status levels belonging to each state.
    function automatic pin_set_t pins_of(input seq_state_e s);
        pin_set_t p;
        p = '{zz_n: 1'b1, ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, bhe_n: 1'b1,
              ble_n: 1'b1, grant: 1'b0, busy: 1'b1, asleep: 1'b0};
        case (s)
            ST_IDLE: begin
                p.grant = 1'b1;
                p.busy  = 1'b0;
            end
            ST_PRG_SETUP, ST_PRG_HOLD: p.zz_n = 1'b0;
            ST_PRG_STROBE: begin
                p.zz_n = 1'b0;
                p.we_n = 1'b0;
            end
            ST_SLP_MIN: begin
                p.zz_n   = 1'b0;
                p.asleep = 1'b1;
            end
            ST_SLP: begin
                p.zz_n   = 1'b0;
                p.asleep = 1'b1;
                p.busy   = 1'b0;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/psram_cmd_gate.sv
module psram_cmd_gate
    import psram_seq_pkg::*;
(
    input  seq_state_e state,
    input  logic       cmd_prog,
    input  logic       cmd_sleep,
    input  logic       cmd_wake,
    output seq_op_e    op,
    output logic       err
);
    logic [1:0] n_cmds;

    always_comb begin
        n_cmds = 2'(cmd_prog) + 2'(cmd_sleep) + 2'(cmd_wake);
        op     = OP_NONE;
        err    = 1'b0;
        if (n_cmds > 2'd1) begin
            err = 1'b1;
        end else if (cmd_prog || cmd_sleep) begin
            if (state == ST_IDLE) op = cmd_prog ? OP_PROG : OP_SLEEP;
            else                  err = 1'b1;
        end else if (cmd_wake) begin
            if (state == ST_SLP) op = OP_WAKE;
            else                 err = 1'b1;
        end
    end
endmodule

// File: rtl/psram_seq_timer.sv
module psram_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
        done = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
    import psram_seq_pkg::*;
#(
    parameter int CLK_NS    = 8,
    parameter int PWRUP_NS  = 200000,
    parameter int ZZWE_NS   = 1000,
    parameter int WE_NS     = 70,
    parameter int SLEEP_NS  = 8000,
    parameter int REC_NS    = 200000,
    parameter int ADDR_W    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              cmd_prog,
    input  logic              cmd_sleep,
    input  logic              cmd_wake,
    input  logic [4:0]        prog_val,
    output logic              zz_n,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic              bhe_n,
    output logic              ble_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic              grant,
    output logic              busy,
    output logic              init_done,
    output logic              asleep,
    output logic              cmd_err
);
    localparam int PWRUP_CYC = ns_to_cyc(PWRUP_NS, CLK_NS);
    localparam int SETUP_CYC = ns_to_cyc(ZZWE_NS, CLK_NS);
    localparam int WE_CYC    = ns_to_cyc(WE_NS, CLK_NS);
    localparam int SLEEP_CYC = ns_to_cyc(SLEEP_NS, CLK_NS);
    localparam int REC_CYC   = ns_to_cyc(REC_NS, CLK_NS);
    localparam int MAX_CYC   = max2(max2(PWRUP_CYC, REC_CYC),
                                    max2(max2(SETUP_CYC, WE_CYC), SLEEP_CYC));
    localparam int CW        = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e st;
        ret_mode_e  mode;
        logic [4:0] val;
        logic       addr_en;
        logic       init;
        logic       err;
        pin_set_t   pins;
    } seq_regs_t;

    seq_regs_t     r_d, r_q;
    seq_op_e       op;
    logic          gate_err;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;

    psram_cmd_gate u_gate (
        .state     (r_q.st),
        .cmd_prog  (cmd_prog),
        .cmd_sleep (cmd_sleep),
        .cmd_wake  (cmd_wake),
        .op        (op),
        .err       (gate_err)
    );

    psram_seq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    always_comb begin
        r_d      = r_q;
        r_d.err  = gate_err;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (r_q.st)
            ST_NOSUPPLY: if (supply_ok) begin
                r_d.st   = ST_PWRUP;
                tmr_load = 1'b1;
                tmr_val  = CW'(PWRUP_CYC - 1);
            end
            ST_PWRUP: if (tmr_done) begin
                r_d.st   = ST_IDLE;
                r_d.init = 1'b1;
            end
            ST_IDLE: begin
                if (op == OP_PROG) begin
                    r_d.st   = ST_PRG_SETUP;
                    r_d.val  = prog_val;
                    r_d.mode = classify(prog_val);
                    tmr_load = 1'b1;
                    tmr_val  = CW'(SETUP_CYC - 1);
                end else if (op == OP_SLEEP) begin
                    r_d.st   = ST_SLP_MIN;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(SLEEP_CYC - 1);
                end
            end
            ST_PRG_SETUP: if (tmr_done) begin
                r_d.st   = ST_PRG_STROBE;
                tmr_load = 1'b1;
                tmr_val  = CW'(WE_CYC - 1);
            end
            ST_PRG_STROBE: if (tmr_done) r_d.st = ST_PRG_HOLD;
            ST_PRG_HOLD:   r_d.st = ST_IDLE;
            ST_SLP_MIN:    if (tmr_done) r_d.st = ST_SLP;
            ST_SLP: if (op == OP_WAKE) begin
                if (r_q.mode == RM_DEEP) begin
                    r_d.st   = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(REC_CYC - 1);
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_RECOVER: if (tmr_done) r_d.st = ST_IDLE;
            default: r_d.st = ST_NOSUPPLY;
        endcase
        if (!supply_ok) begin
            r_d.st   = ST_NOSUPPLY;
            r_d.init = 1'b0;
            r_d.mode = RM_FULL;
        end
        r_d.addr_en = (r_d.st == ST_PRG_SETUP) || (r_d.st == ST_PRG_STROBE) ||
                      (r_d.st == ST_PRG_HOLD);
        r_d.pins    = pins_of(r_d.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_NOSUPPLY;
            r_q.mode <= RM_FULL;
            r_q.pins <= pins_of(ST_NOSUPPLY);
        end else begin
            r_q <= r_d;
        end
    end

    assign zz_n      = r_q.pins.zz_n;
    assign ce_n      = r_q.pins.ce_n;
    assign we_n      = r_q.pins.we_n;
    assign oe_n      = r_q.pins.oe_n;
    assign bhe_n     = r_q.pins.bhe_n;
    assign ble_n     = r_q.pins.ble_n;
    assign grant     = r_q.pins.grant;
    assign busy      = r_q.pins.busy;
    assign asleep    = r_q.pins.asleep;
    assign init_done = r_q.init;
    assign cmd_err   = r_q.err;
    assign addr_o    = r_q.addr_en ? {{(ADDR_W-5){1'b0}}, r_q.val} : '0;

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 1,
    parameter int SLEEP_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic zz_n,
    input logic ce_n,
    input logic we_n,
    input logic oe_n,
    input logic bhe_n,
    input logic ble_n,
    input logic grant,
    input logic busy,
    input logic init_done,
    input logic asleep
);
    logic [31:0] zl_q, wl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zl_q <= '0;
            wl_q <= '0;
        end else begin
            zl_q <= zz_n ? '0 : ((zl_q == '1) ? zl_q : zl_q + 1);
            wl_q <= we_n ? '0 : ((wl_q == '1) ? wl_q : wl_q + 1);
        end
    end

    AST_GRANT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && busy)); // R9
    AST_GRANT_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> init_done); // R2
    AST_ZZ_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !zz_n |-> (ce_n && bhe_n && ble_n && oe_n)); // R3
    AST_STROBE_IN_ZZ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !zz_n); // R3
    AST_STROBE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> (zl_q >= 32'(SETUP_CYC))); // R3
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (wl_q == 32'(WE_CYC))); // R4
    AST_ASLEEP_ZZ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !zz_n); // R6
    AST_SLEEP_MIN_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(zz_n) && $past(asleep)) |-> (zl_q >= 32'(SLEEP_CYC))); // R6

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
    .SETUP_CYC (SETUP_CYC),
    .WE_CYC    (WE_CYC),
    .SLEEP_CYC (SLEEP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .zz_n      (zz_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .bhe_n     (bhe_n),
    .ble_n     (ble_n),
    .grant     (grant),
    .busy      (busy),
    .init_done (init_done),
    .asleep    (asleep)
);

// File: tb/psram_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module psram_pwr_seq_tb_top;
    localparam int CLK   = 8;
    localparam int P_PWR = 800;
    localparam int P_ZW  = 80;
    localparam int P_WE  = 70;
    localparam int P_SL  = 160;
    localparam int P_REC = 400;
    localparam int AW    = 20;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_PWR = cyc(P_PWR);
    localparam int E_ZW  = cyc(P_ZW);
    localparam int E_WE  = cyc(P_WE);
    localparam int E_SL  = cyc(P_SL);
    localparam int E_REC = cyc(P_REC);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic cmd_prog = 1'b0, cmd_sleep = 1'b0, cmd_wake = 1'b0;
    logic [4:0] prog_val = '0;
    logic zz_n, ce_n, we_n, oe_n, bhe_n, ble_n, grant, busy, init_done, asleep, cmd_err;
    logic [AW-1:0] addr_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit exp_deep = 0;
    logic [4:0] mon_val = '0;

    always #(CLK/2) clk = ~clk;

    psram_pwr_seq #(
        .CLK_NS(CLK), .PWRUP_NS(P_PWR), .ZZWE_NS(P_ZW), .WE_NS(P_WE),
        .SLEEP_NS(P_SL), .REC_NS(P_REC), .ADDR_W(AW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .cmd_prog(cmd_prog), .cmd_sleep(cmd_sleep), .cmd_wake(cmd_wake),
        .prog_val(prog_val), .zz_n(zz_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .bhe_n(bhe_n), .ble_n(ble_n), .addr_o(addr_o), .grant(grant), .busy(busy),
        .init_done(init_done), .asleep(asleep), .cmd_err(cmd_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Pin monitor sampled between edges.
    int zl = 0, wl = 0;
    logic we_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!zz_n && !(ce_n && bhe_n && ble_n && oe_n))
                chk(0, "R3 deselect while zz low", {ce_n, bhe_n, ble_n, oe_n}, 15);
            if (!we_n && we_prev)
                chk(zl >= E_ZW, "R3 zz low before strobe", zl, E_ZW);
            if (!we_n)
                chk(addr_o == AW'(mon_val), "R4 address during strobe", int'(addr_o), int'(mon_val));
            if (we_n && !we_prev)
                chk(wl == E_WE, "R4 strobe width", wl, E_WE);
            if (grant)
                chk(!busy && init_done, "R9 grant with busy or uninit", {busy, init_done}, 1);
            zl = zz_n ? 0 : zl + 1;
            wl = we_n ? 0 : wl + 1;
            we_prev = we_n;
        end
    end

    task automatic power_up();
        int n;
        supply_ok = 1'b1;
        @(negedge clk);
        n = 1;
        while (!init_done && n < 100000) begin
            chk(zz_n && ce_n && !grant, "R2 pins held during wait", {zz_n, ce_n, grant}, 6);
            @(negedge clk);
            n++;
        end
        chk(n == E_PWR + 1, "R2 power-up length", n, E_PWR + 1);
        chk(grant == 1'b1, "R2 grant with init", grant, 1);
        exp_deep = 0;
    endtask

    task automatic do_prog(input logic [4:0] v);
        int n;
        mon_val = v;
        prog_val = v;
        cmd_prog = 1'b1;
        @(negedge clk);
        cmd_prog = 1'b0;
        n = 1;
        chk(!zz_n && !grant && busy, "R3 program starts", {zz_n, grant, busy}, 1);
        chk(!cmd_err, "R10 valid program no error", cmd_err, 0);
        while (!grant && n < 100000) begin
            @(negedge clk);
            n++;
        end
        chk(n == E_ZW + E_WE + 2, "R4 program length", n, E_ZW + E_WE + 2);
        exp_deep = !v[4];
    endtask

    task automatic do_sleep(input int hold, input bit early_wake, input bit prog_in_sleep);
        int n, m;
        cmd_sleep = 1'b1;
        @(negedge clk);
        cmd_sleep = 1'b0;
        n = 1;
        chk(asleep && !zz_n && ce_n && !grant, "R6 sleep entry", {asleep, zz_n, ce_n, grant}, 10);
        if (early_wake) begin
            cmd_wake = 1'b1;
            @(negedge clk);
            cmd_wake = 1'b0;
            n++;
            chk(cmd_err == 1'b1, "R10 wake during minimum sleep", cmd_err, 1);
            chk(asleep == 1'b1, "R6 early wake ignored", asleep, 1);
        end
        while (busy && n < 100000) begin
            @(negedge clk);
            n++;
        end
        chk(n == E_SL + 1, "R6 minimum sleep length", n, E_SL + 1);
        repeat (hold) @(negedge clk);
        if (prog_in_sleep) begin
            cmd_prog = 1'b1;
            @(negedge clk);
            cmd_prog = 1'b0;
            chk(cmd_err == 1'b1, "R10 program while asleep", cmd_err, 1);
            chk(asleep && !zz_n, "R10 sleep kept", asleep, 1);
        end
        cmd_wake = 1'b1;
        @(negedge clk);
        cmd_wake = 1'b0;
        m = 1;
        chk(zz_n && !asleep, "R7 zz released on wake", {zz_n, asleep}, 2);
        while (!grant && m < 100000) begin
            chk(busy, "R8 busy during recovery", busy, 1);
            @(negedge clk);
            m++;
        end
        if (exp_deep) chk(m == E_REC + 1, "R8 R5 deep recovery", m, E_REC + 1);
        else          chk(m == 1, "R7 R5 retaining wake", m, 1);
    endtask

    task automatic bad_cmd(input logic p, input logic s, input logic w);
        cmd_prog = p; cmd_sleep = s; cmd_wake = w;
        @(negedge clk);
        cmd_prog = 0; cmd_sleep = 0; cmd_wake = 0;
        chk(cmd_err == 1'b1, "R10 error pulse", cmd_err, 1);
        chk(grant && zz_n, "R10 command ignored", {grant, zz_n}, 3);
        @(negedge clk);
        chk(cmd_err == 1'b0, "R10 pulse one cycle", cmd_err, 0);
    endtask

    initial begin
        #(CLK * 150000);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 waiting for supply
        chk(zz_n && ce_n && we_n && oe_n && bhe_n && ble_n, "R1 idle pins",
            {zz_n, ce_n, we_n, oe_n, bhe_n, ble_n}, 63);
        chk(!grant && !init_done && busy && !asleep, "R1 status",
            {grant, init_done, busy, asleep}, 2);
        cmd_sleep = 1'b1;
        @(negedge clk);
        cmd_sleep = 1'b0;
        chk(cmd_err == 1'b1, "R10 command before init", cmd_err, 1);
        @(negedge clk);
        power_up();

        // directed corner cases
        bad_cmd(1, 1, 0);
        bad_cmd(0, 0, 1);
        do_prog(5'b10110);          // partial refresh
        do_sleep(2, 1'b1, 1'b0);
        do_prog(5'b11000);          // reduced size
        do_sleep(0, 1'b0, 1'b1);
        do_prog(5'b00011);          // deep
        do_sleep(3, 1'b0, 1'b0);

        // R11 supply drop resets the mode
        do_prog(5'b00000);
        supply_ok = 1'b0;
        @(negedge clk);
        chk(!init_done && !grant && busy && zz_n, "R11 drop to waiting",
            {init_done, grant, busy, zz_n}, 3);
        repeat (3) @(negedge clk);
        power_up();
        do_sleep(1, 1'b0, 1'b0);    // retaining mode after repower (R11, R5)

        // random mix
        for (int i = 0; i < 30; i++) begin
            int sel;
            sel = int'($urandom % 4);
            case (sel)
                0, 1: do_prog(5'($urandom));
                2: do_sleep(int'($urandom % 8), 1'($urandom), 1'($urandom));
                default: bad_cmd(1'($urandom), 1'b1, 1'b1);
            endcase
            repeat (int'($urandom % 3)) @(negedge clk);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule